// File: doc/BRIEF.md
# Base Address Register Bank

This block holds the base address registers of one peripheral's configuration header, together with the address decoder that uses them. Each slot is fixed at elaboration. It can be an unused slot, a 32-bit memory region, the lower or upper half of a 64-bit memory region, or an I/O region. Each region has a power-of-two size given by its log2.

Firmware learns a region's size by writing all ones to its register and reading the register back. Address bits below the region size always read as zero, so the value returned encodes the size. Firmware then writes an aligned base.

Every access presents an address and a memory/I/O flag. The decoder reports at most one matching region as a one-hot slot index, together with the offset of the access inside that region. Register writes take effect at the clock edge. Reads and decoding are combinational from the stored state.

Top module: `bar_bank`

## Requirements
- R1: After reset, every writable register bit is zero, so each slot reads back only its read-only type bits.
- R2: Read-only low bits:
  - Bit 0 reads 1 for an I/O region and 0 for memory.
  - A 64-bit lower slot reads bits [3:0] as 4'b0100.
  - A 32-bit memory slot reads bits [3:0] as 4'b0000.
  - An I/O slot reads bit 1 as 0.
- R3: After a write of all ones, a region of size 2^S reads ones in every bit at or above S and zeros below it, apart from the read-only type bits. Memory regions keep bits [3:0] read-only and I/O regions keep bits [1:0] read-only.
- R4: A write updates only the bytes whose byte-enable bit is set (be[k] covers data bits 8k+7:8k). A register holds its value while it is not written.
- R5: An unused slot and any index at or above the slot count read as all zeros, and writes to them have no effect.
- R6: The slot above a 64-bit lower slot stores address bits 63:32 of that region, and every one of its bits is writable.
- R7: A region hits when address bits at or above its size equal the stored base bits and the access type matches the region type. The hit output is then one-hot at the region's (lower) slot index, and the offset output equals the address bits below the size.
- R8: With the memory enable low, no memory access hits. With the I/O enable low, no I/O access hits.
- R9: A region does not hit until its register (the lower register for a 64-bit region) has been written since reset with at least one byte enable set.
- R10: A 32-bit memory region or an I/O region hits only when address bits 63:32 are zero. A 64-bit region compares those bits with its upper slot.
- R11: When programmed regions overlap, only the lowest-indexed matching slot is reported.
- R12: With no valid access or no match, the hit vector, the any-hit flag and the offset are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_idx_i | input | IDX_W | Register index for read and write |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Readback of the indexed register |
| mem_en_i | input | 1 | Memory decode enable |
| io_en_i | input | 1 | I/O decode enable |
| acc_valid_i | input | 1 | Access present |
| acc_io_i | input | 1 | Access is I/O (1) or memory (0) |
| acc_addr_i | input | 64 | Access address |
| hit_o | output | NUM_SLOTS | One-hot matching slot |
| hit_any_o | output | 1 | Some region matched |
| offset_o | output | 64 | Offset inside the matching region |

## Verification
A wrong stored bit shows up at the readback port in the same cycle that its index is presented. It also moves the decode boundary at once: addresses near the base or near the end of a region land in or out of it, and the offset changes. Sweeping addresses across every region, one step below it and one step past it exposes misplaced size masks. Toggling the enables and the access type, and placing two regions in overlapping positions, exposes faults in gating, type matching and priority in the very cycle of the access.

// File: rtl/bar_pkg.sv
package bar_pkg;

  localparam int ADDR_W = 64;
  localparam int REG_W  = 32;

  typedef enum logic [2:0] {
    SK_NONE     = 3'd0,
    SK_MEM32    = 3'd1,
    SK_MEM64_LO = 3'd2,
    SK_MEM64_HI = 3'd3,
    SK_IO       = 3'd4
  } slot_kind_e;

  // writable bits of a slot; lg is the log2 size of the owning region
  function automatic logic [REG_W-1:0] wr_mask(slot_kind_e k, int lg);
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < REG_W; b++) begin
      case (k)
        SK_MEM32, SK_MEM64_LO: m[b] = (b >= lg) && (b >= 4);
        SK_IO:                 m[b] = (b >= lg) && (b >= 2);
        SK_MEM64_HI:           m[b] = (b + REG_W >= lg);
        default:               m[b] = 1'b0;
      endcase
    end
    return m;
  endfunction

  function automatic logic [REG_W-1:0] hw_bits(slot_kind_e k);
    case (k)
      SK_MEM64_LO: return 32'h0000_0004;
      SK_IO:       return 32'h0000_0001;
      default:     return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
  import bar_pkg::*;
#(
  parameter slot_kind_e KIND = SK_MEM32,
  parameter int         LOG2 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [3:0]       be_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             written_o
);

  localparam logic [REG_W-1:0] MASK = wr_mask(KIND, LOG2);
  localparam logic [REG_W-1:0] HW   = hw_bits(KIND);

  logic [REG_W-1:0] q_q;
  logic             written_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q       <= '0;
      written_q <= 1'b0;
    end else if (wr_i) begin
      for (int b = 0; b < 4; b++) begin
        if (be_i[b]) q_q[8*b +: 8] <= wdata_i[8*b +: 8] & MASK[8*b +: 8];
      end
      if (|be_i) written_q <= 1'b1;
    end
  end

  assign rdata_o   = (q_q & MASK) | HW;
  assign written_o = written_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rdata_o));

  assert_prog_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(written_o) |-> $past(wr_i));

endmodule

// File: rtl/bar_match.sv
module bar_match
  import bar_pkg::*;
#(
  parameter slot_kind_e KIND = SK_MEM32,
  parameter int         LOG2 = 12
) (
  input  logic              lo_i,
  input  logic [REG_W-1:0]  lo_val_i,
  input  logic [REG_W-1:0]  hi_val_i,
  input  logic              mem_en_i,
  input  logic              io_en_i,
  input  logic              acc_valid_i,
  input  logic              acc_io_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);

  localparam logic [ADDR_W-1:0] RMASK =
    ~((ADDR_W'(1) << LOG2) - ADDR_W'(1));
  localparam bit IS_REGION = (KIND == SK_MEM32) || (KIND == SK_MEM64_LO) || (KIND == SK_IO);
  localparam bit IS_IO     = (KIND == SK_IO);
  localparam bit WIDE      = (KIND == SK_MEM64_LO);

  logic [ADDR_W-1:0] base;
  logic              sel_en;

  // lo_i carries the programmed flag of the owning register
  always_comb begin
    base   = WIDE ? {hi_val_i, lo_val_i} : {{(ADDR_W-REG_W){1'b0}}, lo_val_i};
    sel_en = IS_IO ? io_en_i : mem_en_i;
    hit_o  = IS_REGION && acc_valid_i && lo_i && sel_en && (acc_io_i == IS_IO)
             && ((addr_i & RMASK) == (base & RMASK));
    off_o  = hit_o ? (addr_i & ~RMASK) : '0;
  end

endmodule

// File: rtl/bar_bank.sv
module bar_bank
  import bar_pkg::*;
#(
  parameter int         NUM_SLOTS = 6,
  parameter slot_kind_e SLOT_KIND [NUM_SLOTS] =
    '{SK_MEM32, SK_IO, SK_MEM64_LO, SK_MEM64_HI, SK_NONE, SK_MEM32},
  parameter int         SLOT_LOG2 [NUM_SLOTS] = '{12, 5, 16, 16, 2, 8},
  localparam int        IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_wr_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic [3:0]           cfg_be_i,
  input  logic [REG_W-1:0]     cfg_wdata_i,
  output logic [REG_W-1:0]     cfg_rdata_o,
  input  logic                 mem_en_i,
  input  logic                 io_en_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_io_i,
  input  logic [ADDR_W-1:0]    acc_addr_i,
  output logic [NUM_SLOTS-1:0] hit_o,
  output logic                 hit_any_o,
  output logic [ADDR_W-1:0]    offset_o
);

  logic [REG_W-1:0]  slot_rd  [NUM_SLOTS];
  logic [ADDR_W-1:0] raw_off  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_wr;
  logic [NUM_SLOTS-1:0] raw_hit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int NX = (g + 1 < NUM_SLOTS) ? g + 1 : g;

    bar_slot #(
      .KIND(SLOT_KIND[g]),
      .LOG2(SLOT_LOG2[g])
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (cfg_wr_i && (cfg_idx_i == IDX_W'(g))),
      .be_i     (cfg_be_i),
      .wdata_i  (cfg_wdata_i),
      .rdata_o  (slot_rd[g]),
      .written_o(slot_wr[g])
    );

    bar_match #(
      .KIND(SLOT_KIND[g]),
      .LOG2(SLOT_LOG2[g])
    ) u_match (
      .lo_i       (slot_wr[g]),
      .lo_val_i   (slot_rd[g]),
      .hi_val_i   (slot_rd[NX]),
      .mem_en_i   (mem_en_i),
      .io_en_i    (io_en_i),
      .acc_valid_i(acc_valid_i),
      .acc_io_i   (acc_io_i),
      .addr_i     (acc_addr_i),
      .hit_o      (raw_hit[g]),
      .off_o      (raw_off[g])
    );
  end

  always_comb begin
    cfg_rdata_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (cfg_idx_i == IDX_W'(i)) cfg_rdata_o = slot_rd[i];
    end
  end

  // lowest index wins on overlap
  always_comb begin
    hit_o    = '0;
    offset_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        hit_o    = '0;
        hit_o[i] = 1'b1;
        offset_o = raw_off[i];
      end
    end
  end

  assign hit_any_o = |raw_hit;

  assert_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));

  assert_mem_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_io_i && !mem_en_i) |-> (hit_o == '0));

  assert_io_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_io_i && !io_en_i) |-> (hit_o == '0));

  assert_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!hit_any_o && offset_o == '0));

endmodule

// File: tb/bar_bank_test.sv
module bar_bank_test;

  localparam int NS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_en = 1'b0, io_en = 1'b0, acc_valid = 1'b0, acc_io = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [NS-1:0] hit;
  logic        hit_any;
  logic [63:0] offset;

  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  // kind codes: 0 unused, 1 mem32, 2 mem64 low, 3 mem64 high, 4 io
  int kind [NS] = '{1, 4, 2, 3, 0, 1};
  int lg   [NS] = '{12, 5, 16, 16, 2, 8};
  logic [31:0] mreg [8];
  bit          mprog [8];

  always #5 clk = ~clk;

  bar_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_idx_i(cfg_idx),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .mem_en_i(mem_en), .io_en_i(io_en), .acc_valid_i(acc_valid),
    .acc_io_i(acc_io), .acc_addr_i(acc_addr), .hit_o(hit),
    .hit_any_o(hit_any), .offset_o(offset)
  );

  function automatic logic [31:0] m_mask(int k, int l);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) begin
      if (k == 1 || k == 2) m[b] = (b >= l) && (b >= 4);
      else if (k == 4)      m[b] = (b >= l) && (b >= 2);
      else if (k == 3)      m[b] = (b + 32 >= l);
    end
    return m;
  endfunction

  function automatic logic [31:0] m_hw(int k);
    return (k == 2) ? 32'h4 : (k == 4) ? 32'h1 : 32'h0;
  endfunction

  function automatic logic [31:0] exp_rd(int idx);
    if (idx >= NS) return 32'h0;
    return (mreg[idx] & m_mask(kind[idx], lg[idx])) | m_hw(kind[idx]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin mreg[i] = '0; mprog[i] = 1'b0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; model_reset();
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic report(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 3'(idx); cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1 cfg_wr = 1'b0;
    if (idx < NS) begin
      for (int b = 0; b < 4; b++) if (be[b]) mreg[idx][8*b +: 8] = d[8*b +: 8];
      mreg[idx] = mreg[idx] & m_mask(kind[idx], lg[idx]);
      if (be != 4'h0) mprog[idx] = 1'b1;
    end
  endtask

  task automatic chk_rd(int idx, string req);
    @(negedge clk); cfg_idx = 3'(idx); #1;
    report(req, 64'(cfg_rdata), 64'(exp_rd(idx)));
  endtask

  task automatic exp_dec(logic [63:0] a, logic io, output logic [NS-1:0] eh,
                         output logic [63:0] eo);
    eh = '0; eo = '0;
    for (int r = 0; r < NS; r++) begin
      logic [63:0] base, rm;
      bit en;
      if (!(kind[r] == 1 || kind[r] == 2 || kind[r] == 4)) continue;
      base = (kind[r] == 2) ? {mreg[r+1], mreg[r]} : {32'h0, mreg[r]};
      rm = ~((64'd1 << lg[r]) - 64'd1);
      en = (kind[r] == 4) ? io_en : mem_en;
      if (mprog[r] && en && (io == (kind[r] == 4)) && ((a & rm) == (base & rm)) && eh == '0) begin
        eh[r] = 1'b1; eo = a & ~rm;
      end
    end
  endtask

  task automatic chk_dec(logic [63:0] a, logic io, string req);
    logic [NS-1:0] eh;
    logic [63:0] eo;
    @(negedge clk); acc_valid = 1'b1; acc_io = io; acc_addr = a; #1;
    exp_dec(a, io, eh, eo);
    report({req, " hit"}, 64'(hit), 64'(eh));
    report({req, " any"}, 64'(hit_any), 64'(eh != '0));
    report({req, " off"}, offset, eo);
    acc_valid = 1'b0;
  endtask

  task automatic sweep(int r);
    logic [63:0] base, sz;
    base = (kind[r] == 2) ? {mreg[r+1], mreg[r]} : {32'h0, mreg[r]};
    base = base & ~((64'd1 << lg[r]) - 64'd1);
    sz = 64'd1 << lg[r];
    for (int k = 0; k < 16; k++) chk_dec(base + 64'(k) * (sz >> 4), kind[r] == 4, "R7 sweep");
    chk_dec(base + sz - 64'd1, kind[r] == 4, "R7 last");
    chk_dec(base - 64'd1, kind[r] == 4, "R7 below");
    chk_dec(base + sz, kind[r] == 4, "R7 past");
    chk_dec(base, kind[r] != 4, "R7 wrong type");
    chk_dec(base | (64'd1 << 40), kind[r] == 4, "R10 upper bits");
  endtask

  initial begin
    model_reset();
    do_reset();
    // R1 R2 R5: reset values and read-only bits
    for (int i = 0; i < 8; i++) chk_rd(i, "R1 R2 R5 reset readback");
    // R9: unprogrammed bases are zero but must not hit
    mem_en = 1'b1; io_en = 1'b1;
    chk_dec(64'h10, 1'b0, "R9 unprogrammed mem");
    chk_dec(64'h4, 1'b1, "R9 unprogrammed io");
    wr(0, 4'h0, 32'h0);
    chk_dec(64'h10, 1'b0, "R9 no-byte write");
    wr(0, 4'hF, 32'h0);
    chk_dec(64'h10, 1'b0, "R9 programmed at zero");
    // R3 R5 R6: sizing with all ones
    for (int i = 0; i < 8; i++) wr(i, 4'hF, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) chk_rd(i, "R3 R6 R5 sizing readback");
    // R4: byte enables
    for (int be = 0; be < 16; be++) begin
      wr(0, 4'hF, 32'h0);
      wr(0, 4'(be), 32'hA5B6_C7D8);
      chk_rd(0, "R4 byte enable");
      wr(3, 4'hF, 32'h1357_9BDF);
      wr(3, 4'(be), 32'hFFFF_FFFF);
      chk_rd(3, "R4 R6 upper byte enable");
    end
    // program bases
    wr(0, 4'hF, 32'h8000_3000);
    wr(1, 4'hF, 32'h0000_1040);
    wr(2, 4'hF, 32'h1234_0000);
    wr(3, 4'hF, 32'h0000_0002);
    wr(5, 4'hF, 32'hC000_0100);
    for (int i = 0; i < 8; i++) chk_rd(i, "R2 R6 programmed readback");
    chk_dec(64'h0000_0000_1234_0100, 1'b0, "R10 64-bit needs upper");
    chk_dec(64'h0000_0002_1234_0100, 1'b0, "R10 64-bit upper match");
    sweep(0); sweep(1); sweep(2); sweep(5);
    // R8: enables
    mem_en = 1'b0;
    chk_dec(64'h8000_3010, 1'b0, "R8 mem disabled");
    chk_dec(64'h1044, 1'b1, "R8 io still on");
    mem_en = 1'b1; io_en = 1'b0;
    chk_dec(64'h1044, 1'b1, "R8 io disabled");
    chk_dec(64'h8000_3010, 1'b0, "R8 mem still on");
    io_en = 1'b1;
    // R11: overlap, slot 5 placed inside slot 0
    wr(5, 4'hF, 32'h8000_3F00);
    chk_dec(64'h8000_3F20, 1'b0, "R11 overlap");
    chk_dec(64'h8000_3E20, 1'b0, "R11 only low slot");
    // R12: no valid access
    @(negedge clk); acc_valid = 1'b0; acc_io = 1'b0; acc_addr = 64'h8000_3F20; #1;
    report("R12 idle hit", 64'(hit), 64'h0);
    report("R12 idle any", 64'(hit_any), 64'h0);
    report("R12 idle off", offset, 64'h0);
    chk_dec(64'h7000_0000, 1'b0, "R12 miss");
    // R1: reset clears programmed state
    do_reset();
    for (int i = 0; i < 8; i++) chk_rd(i, "R1 second reset");
    chk_dec(64'h8000_3010, 1'b0, "R9 after reset");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule